// File: doc/BRIEF.md
# Special Register Read Selector

This unit serves the "move from special register" path of a small soft processor core. A 16-bit selector code picks one of the core's special-purpose registers and a flag asks for the extended part of a wide register. When a valid strobe accompanies a request, the unit returns a 32-bit word on the following clock edge. The readable set covers the program counter, processor status, the exception capture registers, the floating-point status, stream-exception data, the stack limit pair, the memory-management registers, the words of a translation buffer entry and thirteen version registers.

Elaboration parameters decide which register groups the core actually has. If a selector names a group that is absent, or no register at all, the unit returns zero and raises an invalid flag alongside the result. The two words of the translation buffer come from a 64-entry array, and the entry is picked by the current contents of the buffer index register. When the address width exceeds 32 bits, the exception address, the translation low word and version registers 6 to 9 each carry extra upper bits, and an extended read returns those bits. A load port writes any register, or any upper part, by the same selector codes, so the storage can be filled for test.

Top module: `spr_read_unit`

## Requirements
- R1: A request presented with `req_valid_i` high yields `rsp_valid_o` high on the next cycle, with its data and invalid flag; without a request, `rsp_valid_o` and `rsp_invalid_o` are low on the next cycle.
- R2: With the extended flag clear, selector 0x0000 returns the program counter, 0x0001 the status register, 0x0005 the exception status, 0x0007 the floating-point status, 0x000B the branch target and 0x000D the stream-exception data.
- R3: Selector 0x0800 returns the stack low limit and 0x0802 returns the stack high limit.
- R4: Selector 0x1000 returns the process ID, 0x1001 the zone protection register, 0x1002 the translation index, and 0x2000 to 0x200C return version registers 0 to 12.
- R5: Selectors 0x1003 and 0x1004 return the low and high word of the translation entry whose number is bits [5:0] of the translation index register.
- R6: With the extended flag set, selectors 0x0003, 0x1003 and 0x2006 to 0x2009 return the upper ADDR_SIZE-32 bits of the wide register, zero-extended into bits [ADDR_SIZE-33:0] of the result.
- R7: With the extended flag set, any other selector is invalid.
- R8: With the extended flag clear, 0x0003, 0x1003 and 0x2006 to 0x2009 return the low 32 bits of the wide register.
- R9: Exception address, exception status and branch target read only when exception support is enabled; floating-point status only with the FPU enabled; the stack pair only with stack protection enabled; stream-exception data only with stream exceptions enabled.
- R10: Process ID, zone protection and both translation words read only when the MMU mode exceeds 1 and the translation access mode is 1 or 3; the translation index reads when the MMU mode exceeds 1 and the access mode exceeds 0.
- R11: Version register 0 reads when the version level is 1 or 2; version registers 1 to 12 read only at level 2.
- R12: With ADDR_SIZE equal to 32, every extended read is invalid.
- R13: An undefined or disabled selector returns zero data and raises `rsp_invalid_o` in the same cycle as `rsp_valid_o`; after reset both are low.
- R14: A load with `ld_en_i` high writes `ld_data_i` to the register named by `ld_sel_i` (its upper part when `ld_ext_i` is set, taking the low ADDR_SIZE-32 data bits); loads to 0x1003 and 0x1004 write the translation entry selected by the current index register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request strobe |
| req_sel_i | input | 16 | Selector code of the register to read |
| req_ext_i | input | 1 | Read the extended upper part |
| ld_en_i | input | 1 | Load strobe |
| ld_sel_i | input | 16 | Selector code of the register to load |
| ld_ext_i | input | 1 | Load the extended upper part |
| ld_data_i | input | 32 | Load data |
| rsp_valid_o | output | 1 | Result valid, one cycle after the request |
| rsp_data_o | output | 32 | Result word |
| rsp_invalid_o | output | 1 | Selector undefined or disabled |

## Verification
The hardest case to reach is a translation word read, since the entry it returns depends on an earlier load to the index register and that entry must hold distinct data. The stimulus loads several entries by stepping the index register, including entry 63 and an index value with bits above bit 5 set, and then moves the index again before each read. The configuration gating cannot change at run time, so a second instance built with a 32-bit address, no exception or stack support, index-only access to the translation buffer and the basic version level receives the same stimulus and is checked against its own expectations.

// File: rtl/spr_rd_pkg.sv
package spr_rd_pkg;
  typedef logic [4:0] slot_t;

  localparam int NUM_REG = 25;

  localparam slot_t S_PC    = 5'd0;
  localparam slot_t S_MSR   = 5'd1;
  localparam slot_t S_EAR   = 5'd2;
  localparam slot_t S_ESR   = 5'd3;
  localparam slot_t S_FSR   = 5'd4;
  localparam slot_t S_BTR   = 5'd5;
  localparam slot_t S_EDR   = 5'd6;
  localparam slot_t S_SLR   = 5'd7;
  localparam slot_t S_SHR   = 5'd8;
  localparam slot_t S_PID   = 5'd9;
  localparam slot_t S_ZPR   = 5'd10;
  localparam slot_t S_TLBX  = 5'd11;
  localparam slot_t S_PVR0  = 5'd12;
  localparam slot_t S_TLBLO = 5'd25;
  localparam slot_t S_TLBHI = 5'd26;
  localparam slot_t S_NONE  = 5'd31;

  // registers that carry an upper address-extension part
  function automatic logic has_ext_part(int s);
    return (s == int'(S_EAR)) ||
           (s >= int'(S_PVR0) + 6 && s <= int'(S_PVR0) + 9);
  endfunction
endpackage

// File: rtl/spr_decode.sv
module spr_decode
  import spr_rd_pkg::*;
#(
  parameter bit GATE          = 1'b1,
  parameter int ADDR_SIZE     = 44,
  parameter int EXC_EN        = 1,
  parameter int FPU_EN        = 1,
  parameter int STACK_EN      = 1,
  parameter int STREAM_EXC_EN = 1,
  parameter int MMU_MODE      = 3,
  parameter int TLB_ACCESS    = 3,
  parameter int VER_LEVEL     = 2
) (
  input  logic [15:0] sel_i,
  input  logic        ext_i,
  output slot_t       slot_o,
  output logic        ok_o
);
  localparam bit EXC_OK     = EXC_EN != 0;
  localparam bit FPU_OK     = FPU_EN != 0;
  localparam bit STK_OK     = STACK_EN != 0;
  localparam bit EDR_OK     = STREAM_EXC_EN != 0;
  localparam bit TLB_RD_OK  = MMU_MODE > 1 && (TLB_ACCESS == 1 || TLB_ACCESS == 3);
  localparam bit TLBX_OK    = MMU_MODE > 1 && TLB_ACCESS > 0;
  localparam bit PVR0_OK    = VER_LEVEL == 1 || VER_LEVEL == 2;
  localparam bit PVR_ALL_OK = VER_LEVEL == 2;
  localparam bit EXT_OK     = ADDR_SIZE > 32;

  slot_t slot;
  logic  en;

  always_comb begin
    slot = S_NONE;
    en   = 1'b0;
    if (ext_i) begin
      case (sel_i)
        16'h0003: begin slot = S_EAR;   en = EXC_OK && EXT_OK;    end
        16'h1003: begin slot = S_TLBLO; en = TLB_RD_OK && EXT_OK; end
        16'h2006, 16'h2007, 16'h2008, 16'h2009: begin
          slot = S_PVR0 + slot_t'(sel_i[3:0]);
          en   = PVR_ALL_OK && EXT_OK;
        end
        default: ;
      endcase
    end else begin
      case (sel_i)
        16'h0000: begin slot = S_PC;    en = 1'b1;      end
        16'h0001: begin slot = S_MSR;   en = 1'b1;      end
        16'h0003: begin slot = S_EAR;   en = EXC_OK;    end
        16'h0005: begin slot = S_ESR;   en = EXC_OK;    end
        16'h0007: begin slot = S_FSR;   en = FPU_OK;    end
        16'h000B: begin slot = S_BTR;   en = EXC_OK;    end
        16'h000D: begin slot = S_EDR;   en = EDR_OK;    end
        16'h0800: begin slot = S_SLR;   en = STK_OK;    end
        16'h0802: begin slot = S_SHR;   en = STK_OK;    end
        16'h1000: begin slot = S_PID;   en = TLB_RD_OK; end
        16'h1001: begin slot = S_ZPR;   en = TLB_RD_OK; end
        16'h1002: begin slot = S_TLBX;  en = TLBX_OK;   end
        16'h1003: begin slot = S_TLBLO; en = TLB_RD_OK; end
        16'h1004: begin slot = S_TLBHI; en = TLB_RD_OK; end
        default: begin
          if (sel_i[15:4] == 12'h200 && sel_i[3:0] <= 4'd12) begin
            slot = S_PVR0 + slot_t'(sel_i[3:0]);
            en   = (sel_i[3:0] == 4'd0) ? PVR0_OK : PVR_ALL_OK;
          end
        end
      endcase
    end
    slot_o = slot;
    ok_o   = (slot != S_NONE) && (!GATE || en);
  end
endmodule

// File: rtl/spr_bank.sv
module spr_bank
  import spr_rd_pkg::*;
#(
  parameter int EXT_W   = 12,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             wext_i,
  input  slot_t            wslot_i,
  input  logic [31:0]      wdata_i,
  input  slot_t            rslot_i,
  output logic [31:0]      rlo_o,
  output logic [EXT_W-1:0] rext_o,
  output logic [31:0]      tlbx_o
);
  logic [31:0]      lo_q  [NUM_REG];
  logic [EXT_W-1:0] ext_q [NUM_REG];

  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    logic [31:0] lo_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      lo_r <= '0;
      else if (we_i && !wext_i && wslot_i == slot_t'(g)) lo_r <= wdata_i;
    end
    assign lo_q[g] = lo_r;

    if (HAS_EXT && has_ext_part(g)) begin : g_ext
      logic [EXT_W-1:0] ext_r;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                     ext_r <= '0;
        else if (we_i && wext_i && wslot_i == slot_t'(g)) ext_r <= wdata_i[EXT_W-1:0];
      end
      assign ext_q[g] = ext_r;
    end else begin : g_noext
      assign ext_q[g] = '0;
    end
  end

  always_comb begin
    rlo_o  = '0;
    rext_o = '0;
    for (int i = 0; i < NUM_REG; i++) begin
      if (rslot_i == slot_t'(i)) begin
        rlo_o  = lo_q[i];
        rext_o = ext_q[i];
      end
    end
  end

  assign tlbx_o = lo_q[S_TLBX];

  p_tlbx_load_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wext_i && wslot_i == S_TLBX) |=> tlbx_o == $past(wdata_i));
endmodule

// File: rtl/spr_tlb.sv
module spr_tlb #(
  parameter int DEPTH = 64,
  parameter int EXT_W = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             we_lo_i,
  input  logic             we_ext_i,
  input  logic             we_hi_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      lo_o,
  output logic [EXT_W-1:0] ext_o,
  output logic [31:0]      hi_o
);
  logic [31:0]      lo_q  [DEPTH];
  logic [EXT_W-1:0] ext_q [DEPTH];
  logic [31:0]      hi_q  [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        lo_q[i]  <= '0;
        ext_q[i] <= '0;
        hi_q[i]  <= '0;
      end
    end else begin
      if (we_lo_i)  lo_q[idx_i]  <= wdata_i;
      if (we_ext_i) ext_q[idx_i] <= wdata_i[EXT_W-1:0];
      if (we_hi_i)  hi_q[idx_i]  <= wdata_i;
    end
  end

  assign lo_o  = lo_q[idx_i];
  assign ext_o = ext_q[idx_i];
  assign hi_o  = hi_q[idx_i];

  p_tlb_lo_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_lo_i ##1 $stable(idx_i) |-> lo_o == $past(wdata_i));
  p_tlb_hi_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_hi_i ##1 $stable(idx_i) |-> hi_o == $past(wdata_i));
endmodule

// File: rtl/spr_read_unit.sv
module spr_read_unit
  import spr_rd_pkg::*;
#(
  parameter int ADDR_SIZE     = 44,
  parameter int TLB_DEPTH     = 64,
  parameter int EXC_EN        = 1,
  parameter int FPU_EN        = 1,
  parameter int STACK_EN      = 1,
  parameter int STREAM_EXC_EN = 1,
  parameter int MMU_MODE      = 3,
  parameter int TLB_ACCESS    = 3,
  parameter int VER_LEVEL     = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [15:0] req_sel_i,
  input  logic        req_ext_i,
  input  logic        ld_en_i,
  input  logic [15:0] ld_sel_i,
  input  logic        ld_ext_i,
  input  logic [31:0] ld_data_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_data_o,
  output logic        rsp_invalid_o
);
  localparam bit HAS_EXT = ADDR_SIZE > 32;
  localparam int EXT_W   = HAS_EXT ? ADDR_SIZE - 32 : 1;
  localparam int IDX_W   = $clog2(TLB_DEPTH);
  localparam logic [31:0] EXT_MASK = 32'((64'd1 << EXT_W) - 64'd1);

  slot_t rd_slot, ld_slot;
  logic  rd_ok, ld_ok;

  spr_decode #(
    .GATE(1'b1), .ADDR_SIZE(ADDR_SIZE), .EXC_EN(EXC_EN), .FPU_EN(FPU_EN),
    .STACK_EN(STACK_EN), .STREAM_EXC_EN(STREAM_EXC_EN), .MMU_MODE(MMU_MODE),
    .TLB_ACCESS(TLB_ACCESS), .VER_LEVEL(VER_LEVEL)
  ) u_rd_dec (
    .sel_i(req_sel_i), .ext_i(req_ext_i), .slot_o(rd_slot), .ok_o(rd_ok)
  );

  // load path is not gated: storage is filled regardless of configuration
  spr_decode #(
    .GATE(1'b0), .ADDR_SIZE(ADDR_SIZE), .EXC_EN(EXC_EN), .FPU_EN(FPU_EN),
    .STACK_EN(STACK_EN), .STREAM_EXC_EN(STREAM_EXC_EN), .MMU_MODE(MMU_MODE),
    .TLB_ACCESS(TLB_ACCESS), .VER_LEVEL(VER_LEVEL)
  ) u_ld_dec (
    .sel_i(ld_sel_i), .ext_i(ld_ext_i), .slot_o(ld_slot), .ok_o(ld_ok)
  );

  logic [31:0]      bank_lo, tlbx;
  logic [EXT_W-1:0] bank_ext;
  logic             ld_go;

  assign ld_go = ld_en_i && ld_ok;

  spr_bank #(.EXT_W(EXT_W), .HAS_EXT(HAS_EXT)) u_bank (
    .clk_i, .rst_ni,
    .we_i(ld_go), .wext_i(ld_ext_i), .wslot_i(ld_slot), .wdata_i(ld_data_i),
    .rslot_i(rd_slot), .rlo_o(bank_lo), .rext_o(bank_ext), .tlbx_o(tlbx)
  );

  logic [31:0]      tlb_lo, tlb_hi;
  logic [EXT_W-1:0] tlb_ext;
  logic             we_lo, we_ext, we_hi;

  assign we_lo  = ld_go && ld_slot == S_TLBLO && !ld_ext_i;
  assign we_ext = ld_go && ld_slot == S_TLBLO && ld_ext_i && HAS_EXT;
  assign we_hi  = ld_go && ld_slot == S_TLBHI && !ld_ext_i;

  spr_tlb #(.DEPTH(TLB_DEPTH), .EXT_W(EXT_W)) u_tlb (
    .clk_i, .rst_ni,
    .idx_i(tlbx[IDX_W-1:0]),
    .we_lo_i(we_lo), .we_ext_i(we_ext), .we_hi_i(we_hi), .wdata_i(ld_data_i),
    .lo_o(tlb_lo), .ext_o(tlb_ext), .hi_o(tlb_hi)
  );

  logic [31:0]      sel_lo, rd_word;
  logic [EXT_W-1:0] sel_ext;

  always_comb begin
    case (rd_slot)
      S_TLBLO: begin sel_lo = tlb_lo; sel_ext = tlb_ext; end
      S_TLBHI: begin sel_lo = tlb_hi; sel_ext = '0;      end
      default: begin sel_lo = bank_lo; sel_ext = bank_ext; end
    endcase
    if (!rd_ok)         rd_word = '0;
    else if (req_ext_i) rd_word = 32'(sel_ext);
    else                rd_word = sel_lo;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_invalid_o <= 1'b0;
      rsp_data_o    <= '0;
    end else begin
      rsp_valid_o   <= req_valid_i;
      rsp_invalid_o <= req_valid_i && !rd_ok;
      if (req_valid_i) rsp_data_o <= rd_word;
    end
  end

  p_rsp_follows_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_rsp_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !rsp_invalid_o);
  p_inv_zero_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_invalid_o |-> rsp_valid_o && rsp_data_o == '0);
  p_ext_narrow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ext_i) |=> rsp_invalid_o || (rsp_data_o & ~EXT_MASK) == '0);
  p_ext_needs_width_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ext_i && !HAS_EXT) |=> rsp_invalid_o);
endmodule

// File: tb/spr_read_unit_test.sv
`timescale 1ns/1ps
module spr_read_unit_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        req_valid, req_ext, ld_en, ld_ext;
  logic [15:0] req_sel, ld_sel;
  logic [31:0] ld_data;
  logic        f_valid, f_inv, m_valid, m_inv;
  logic [31:0] f_data, m_data;

  spr_read_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_sel_i(req_sel), .req_ext_i(req_ext),
    .ld_en_i(ld_en), .ld_sel_i(ld_sel), .ld_ext_i(ld_ext), .ld_data_i(ld_data),
    .rsp_valid_o(f_valid), .rsp_data_o(f_data), .rsp_invalid_o(f_inv)
  );

  spr_read_unit #(
    .ADDR_SIZE(32), .EXC_EN(0), .FPU_EN(1), .STACK_EN(0), .STREAM_EXC_EN(0),
    .MMU_MODE(2), .TLB_ACCESS(2), .VER_LEVEL(1)
  ) uut_min (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_sel_i(req_sel), .req_ext_i(req_ext),
    .ld_en_i(ld_en), .ld_sel_i(ld_sel), .ld_ext_i(ld_ext), .ld_data_i(ld_data),
    .rsp_valid_o(m_valid), .rsp_data_o(m_data), .rsp_invalid_o(m_inv)
  );

  localparam logic [31:0] FULL_MASK = 32'h0000_0FFF; // 44-bit address: 12 upper bits

  typedef struct {
    logic        inv;
    logic [31:0] data;
    logic [15:0] sel;
    bit          ext;
    string       req;
  } exp_t;

  exp_t q_full[$];
  exp_t q_min[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_lo  [logic [15:0]];
  logic [31:0] m_ext [logic [15:0]];
  logic [31:0] t_lo [64], t_ext [64], t_hi [64];

  function automatic logic [31:0] lo_of(logic [15:0] s);
    return m_lo.exists(s) ? m_lo[s] : 32'h0;
  endfunction
  function automatic logic [31:0] ext_of(logic [15:0] s);
    return m_ext.exists(s) ? m_ext[s] : 32'h0;
  endfunction

  // full: all groups on, 44-bit address; min: see uut_min parameters
  function automatic bit is_valid(bit full, logic [15:0] s, bit e);
    if (e) return full && (s == 16'h0003 || s == 16'h1003 || (s >= 16'h2006 && s <= 16'h2009));
    case (s)
      16'h0000, 16'h0001, 16'h0007, 16'h1002: return 1'b1;
      16'h0003, 16'h0005, 16'h000B, 16'h000D, 16'h0800, 16'h0802,
      16'h1000, 16'h1001, 16'h1003, 16'h1004: return full;
      default: begin
        if (s >= 16'h2000 && s <= 16'h200C) return full || s == 16'h2000;
        return 1'b0;
      end
    endcase
  endfunction

  function automatic string tag_of(bit full, logic [15:0] s, bit e);
    if (!full) begin
      if (e) return "R12";
      if (s == 16'h0003 || s == 16'h0005 || s == 16'h000B || s == 16'h000D ||
          s == 16'h0800 || s == 16'h0802) return "R9";
      if (s[15:12] == 4'h1) return "R10";
      if (s[15:12] == 4'h2) return "R11";
      return "R13";
    end
    if (e) return is_valid(1, s, e) ? "R6" : "R7";
    if (!is_valid(1, s, e)) return "R13";
    if (s == 16'h1003 || s == 16'h1004) return "R5";
    if (s == 16'h1002) return "R14";
    if (s == 16'h0003 || (s >= 16'h2006 && s <= 16'h2009)) return "R8";
    if (s[15:8] == 8'h08) return "R3";
    if (s[15:12] == 4'h1 || s[15:12] == 4'h2) return "R4";
    return "R2";
  endfunction

  function automatic exp_t expect_rd(bit full, logic [15:0] s, bit e);
    exp_t x;
    logic [5:0] idx;
    x.sel = s; x.ext = e; x.req = tag_of(full, s, e);
    x.inv = 1'b0; x.data = 32'h0;
    idx = lo_of(16'h1002)[5:0];
    if (!is_valid(full, s, e)) begin
      x.inv = 1'b1;
    end else if (e) begin
      x.data = (s == 16'h1003) ? t_ext[idx] : ext_of(s);
    end else if (s == 16'h1003) begin
      x.data = t_lo[idx];
    end else if (s == 16'h1004) begin
      x.data = t_hi[idx];
    end else begin
      x.data = lo_of(s);
    end
    return x;
  endfunction

  task automatic load(logic [15:0] s, bit e, logic [31:0] d);
    logic [5:0] idx;
    @(negedge clk);
    ld_en = 1'b1; ld_sel = s; ld_ext = e; ld_data = d;
    idx = lo_of(16'h1002)[5:0];
    if (e) begin
      if (s == 16'h1003) t_ext[idx] = d & FULL_MASK;
      else               m_ext[s]   = d & FULL_MASK;
    end else if (s == 16'h1003) t_lo[idx] = d;
    else if (s == 16'h1004)     t_hi[idx] = d;
    else                        m_lo[s]   = d;
    @(posedge clk);
    #1 ld_en = 1'b0;
  endtask

  task automatic rd(logic [15:0] s, bit e);
    @(negedge clk);
    req_valid = 1'b1; req_sel = s; req_ext = e;
    q_full.push_back(expect_rd(1, s, e));
    q_min.push_back(expect_rd(0, s, e));
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic cmp(string inst, exp_t x, logic [31:0] d, logic inv);
    n_run++;
    if (d !== x.data || inv !== x.inv) begin
      n_fail++;
      $display("FAIL %s %s sel=%h ext=%0b: got inv=%0b data=%h, expected inv=%0b data=%h",
               x.req, inst, x.sel, x.ext, inv, d, x.inv, x.data);
    end
  endtask

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h, expected %h", r, what, act, exp);
    end
  endtask

  // monitor: R1 responses only for requests, in order
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (f_valid) begin
        if (q_full.size() == 0) chk("R1", "full unexpected response", 32'd1, 32'd0);
        else cmp("full", q_full.pop_front(), f_data, f_inv);
      end else if (f_inv) chk("R13", "full invalid without response", 32'd1, 32'd0);
      if (m_valid) begin
        if (q_min.size() == 0) chk("R1", "min unexpected response", 32'd1, 32'd0);
        else cmp("min", q_min.pop_front(), m_data, m_inv);
      end else if (m_inv) chk("R13", "min invalid without response", 32'd1, 32'd0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL R1 watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] base [16];
    logic [15:0] undef [6];
    base = '{16'h0000, 16'h0001, 16'h0003, 16'h0005, 16'h0007, 16'h000B, 16'h000D,
             16'h0800, 16'h0802, 16'h1000, 16'h1001, 16'h2000, 16'h2001, 16'h2006,
             16'h2009, 16'h200C};
    undef = '{16'h0002, 16'h000C, 16'h0801, 16'h1005, 16'h200D, 16'hFFFF};
    for (int i = 0; i < 64; i++) begin t_lo[i] = 0; t_ext[i] = 0; t_hi[i] = 0; end
    rst_n = 1'b0; req_valid = 0; req_ext = 0; req_sel = 0;
    ld_en = 0; ld_ext = 0; ld_sel = 0; ld_data = 0;
    repeat (3) @(posedge clk);
    #1;
    // R13: reset state
    chk("R13", "full rsp_valid after reset", {31'b0, f_valid}, 32'd0);
    chk("R13", "full rsp_invalid after reset", {31'b0, f_inv}, 32'd0);
    chk("R13", "min rsp_valid after reset", {31'b0, m_valid}, 32'd0);
    rst_n = 1'b1;

    // R14: fill every plain register with a distinct word
    for (int i = 0; i < 16; i++) load(base[i], 0, {base[i] ^ 16'hC35A, base[i] + 16'h1111});
    for (int p = 2; p <= 12; p++)
      if (p != 6 && p != 9) load(16'h2000 + 16'(p), 0, {16'hBEE0 + 16'(p), 16'h7000 + 16'(p)});
    load(16'h2007, 0, 32'h1234_2007);
    load(16'h2008, 0, 32'h1234_2008);
    load(16'h0003, 1, 32'hFFFF_FABC);
    load(16'h2006, 1, 32'h0000_0106);
    load(16'h2007, 1, 32'h0000_0E07);
    load(16'h2008, 1, 32'h5555_5808);
    load(16'h2009, 1, 32'h0000_0FFF);

    // R14: translation entries written through the index register
    begin
      int ents [4] = '{0, 7, 63, 21};
      for (int k = 0; k < 4; k++) begin
        load(16'h1002, 0, 32'(ents[k]));
        load(16'h1003, 0, 32'hA000_0000 + 32'(ents[k]));
        load(16'h1003, 1, 32'h0000_0C00 + 32'(ents[k]));
        load(16'h1004, 0, 32'hB000_0000 + 32'(ents[k]));
      end
    end

    // R2 R3 R4 R8 R9 R11: plain reads, back to back
    for (int i = 0; i < 16; i++) rd(base[i], 0);
    for (int p = 0; p <= 12; p++) rd(16'h2000 + 16'(p), 0);
    rd(16'h1002, 0);
    // R5 R10: entry 21, then index 0x47 selects entry 7, then entry 63
    rd(16'h1003, 0); rd(16'h1004, 0); rd(16'h1003, 1);
    load(16'h1002, 0, 32'h0000_0047);
    rd(16'h1002, 0); rd(16'h1003, 0); rd(16'h1004, 0); rd(16'h1003, 1);
    load(16'h1002, 0, 32'hFFFF_FFFF);
    rd(16'h1003, 0); rd(16'h1004, 0); rd(16'h1003, 1);
    load(16'h1002, 0, 32'h0000_0005); // unwritten entry reads zero
    rd(16'h1003, 0); rd(16'h1004, 0);
    // R6 R12: extended reads of every wide register
    rd(16'h0003, 1);
    for (int p = 6; p <= 9; p++) rd(16'h2000 + 16'(p), 1);
    // R7: extended flag on narrow or unknown selectors
    rd(16'h0000, 1); rd(16'h0005, 1); rd(16'h1004, 1); rd(16'h2005, 1); rd(16'h200A, 1);
    // R13: undefined selectors
    for (int i = 0; i < 6; i++) rd(undef[i], 0);
    // R1: idle gap, then single reads
    repeat (4) @(posedge clk);
    rd(16'h0001, 0);
    repeat (2) @(posedge clk);
    rd(16'h0800, 0);
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "full responses outstanding", 32'(q_full.size()), 32'd0);
    chk("R1", "min responses outstanding", 32'(q_min.size()), 32'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule